// File: doc/BRIEF.md
# Triangle Spread-Spectrum Profile Controller

This block shapes a triangular modulation profile for the feedback divider of a fractional-N PLL. It advances once per `tick`, a single-cycle enable pulse that runs at one eighth of the VCO rate. On each tick it produces a signed divider-offset word for the sigma-delta modulator downstream. One full modulation period is an exact, programmable number of ticks. The period can therefore match a video line length, and the modulation rate is the tick rate divided by that count.

The period is split into two ramps of equal length. With H as half the period, the offset climbs for H ticks and then falls for H ticks. The depth is set by a separate amplitude value A. The offset is centred on zero and spans from -A up to +A.

The per-tick step is A/H. A remainder carries the fractional part of that step, so each ramp ends exactly on its target value. The period, amplitude and modulus inputs are shadowed. They are captured only on the tick that opens a new period, so a profile never changes part-way through. The captured modulus is presented on `mod_o` for the downstream modulator.

Top module: `tri_spread_ctl`

## Requirements
- R1: While `rst_n` is low, and after its release until the first tick, `offset_o`, `dir_up_o`, `period_start_o` and `mod_o` are all zero.
- R2: A clock edge that samples `ss_en_n` high sets `offset_o` to 0, clears `dir_up_o` and drops all progress through the period. The next tick with `ss_en_n` low opens a new period.
- R3: A period opens on the first enabled tick after reset or disable, and again on the tick that follows the completion of 2·H ticks. `period_start_o` is 1 for exactly one clock, the clock after that tick.
- R4: `cfg_period`, `cfg_amp` and `cfg_mod` are captured only on the tick that opens a period. `mod_o` shows the captured modulus and holds it until the next period opens.
- R5: The half-period is H = `cfg_period[10:1]`. Bit 0 of `cfg_period` is ignored, so an odd count behaves as the even count below it.
- R6: A period-opening tick that sees H < 2 (a period below 4) does not open a period. It sets `offset_o` to 0 and clears `dir_up_o`, leaves `period_start_o` low and leaves `mod_o` unchanged. The check is repeated on every later tick.
- R7: `dir_up_o` is 1 after each of the first H ticks of a period and 0 after each of the last H ticks.
- R8: `offset_o` is a 12-bit two's-complement value. After the k-th tick of a period it equals 2·floor(k·A/H) − A for k ≤ H, and A − 2·floor((k−H)·A/H) for H < k ≤ 2H. It therefore ends every period at exactly −A.
- R9: While `ss_en_n` is low, a clock edge without `tick` leaves `offset_o`, `dir_up_o` and `mod_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle step enable (VCO rate / 8) |
| ss_en_n | input | 1 | Active-low spread enable |
| cfg_period | input | 11 | Shadow: ticks per modulation period |
| cfg_amp | input | 11 | Shadow: spread amplitude A |
| cfg_mod | input | 13 | Shadow: modulus for the downstream modulator |
| offset_o | output | 12 | Signed divider offset |
| dir_up_o | output | 1 | High while the profile is rising |
| period_start_o | output | 1 | One-clock strobe when a period opens |
| mod_o | output | 13 | Modulus captured at the last period start |

## Verification
The bench targets several ways the block could go wrong, each with a visible symptom:

- **Non-dividing step.** Amplitudes that do not divide by H would leave a ramp short of its peak and let the profile drift from zero between periods if the remainder were lost. Zero amplitude and full-scale amplitude are exercised as well.
- **Mid-period parameter change.** A change written part-way through a period would bend the running profile if the shadow stage leaked. The bench checks that it does not.
- **Odd and too-short periods.** An odd period would shift the boundary by one tick if bit 0 were not dropped. A too-short period would leave the offset stuck at −A, or raise a false strobe, if parking were missing.
- **Disable in mid-ramp.** The next enable must open a fresh period with the strobe, rather than resume the old count.

// File: rtl/tri_spread_pkg.sv
package tri_spread_pkg;
  localparam int unsigned DEF_PER_W = 11;
  localparam int unsigned DEF_AMP_W = 11;
  localparam int unsigned DEF_MOD_W = 13;
  localparam int unsigned MIN_HALF  = 2;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/tri_spread_shadow.sv
module tri_spread_shadow #(
  parameter int unsigned HALF_W = 10,
  parameter int unsigned AMP_W  = 11,
  parameter int unsigned MOD_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HALF_W-1:0] half_d,
  input  logic [AMP_W-1:0]  amp_d,
  input  logic [MOD_W-1:0]  mod_d,
  output logic [HALF_W-1:0] half_q,
  output logic [AMP_W-1:0]  amp_q,
  output logic [MOD_W-1:0]  mod_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      amp_q  <= '0;
      mod_q  <= '0;
    end else if (load) begin
      half_q <= half_d;
      amp_q  <= amp_d;
      mod_q  <= mod_d;
    end
  end
endmodule

// File: rtl/tri_spread_seq.sv
module tri_spread_seq
  import tri_spread_pkg::*;
#(
  parameter  int unsigned PER_W  = 11,
  localparam int unsigned HALF_W = PER_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [HALF_W-1:0] act_half,
  output logic              at_bound,
  output logic [HALF_W-1:0] eff_half,
  output logic              start_evt,
  output logic              step_evt,
  output logic              park_evt,
  output logic              go_up,
  output logic              dir_up,
  output logic              strobe
);
  logic [PER_W-1:0] cnt_q;
  ramp_dir_e        dir_q;
  logic             strobe_q;
  logic             cfg_ok;
  logic [PER_W-1:0] span;
  logic             last_step;

  assign at_bound  = (cnt_q == '0);
  assign cfg_ok    = (cfg_half >= HALF_W'(MIN_HALF));
  assign eff_half  = at_bound ? cfg_half : act_half;
  assign start_evt = tick && enable && at_bound && cfg_ok;
  assign park_evt  = tick && enable && at_bound && !cfg_ok;
  assign step_evt  = tick && enable && (!at_bound || cfg_ok);
  assign span      = {eff_half, 1'b0};
  assign go_up     = (cnt_q < {1'b0, eff_half});
  assign last_step = (cnt_q == span - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      dir_q    <= DIR_DOWN;
      strobe_q <= 1'b0;
    end else if (!enable) begin
      cnt_q    <= '0;
      dir_q    <= DIR_DOWN;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= start_evt;
      if (park_evt) begin
        dir_q <= DIR_DOWN;
      end else if (step_evt) begin
        cnt_q <= last_step ? '0 : cnt_q + PER_W'(1);
        dir_q <= go_up ? DIR_UP : DIR_DOWN;
      end
    end
  end

  assign dir_up = (dir_q == DIR_UP);
  assign strobe = strobe_q;
endmodule

// File: rtl/tri_spread_ramp.sv
module tri_spread_ramp #(
  parameter  int unsigned PER_W  = 11,
  parameter  int unsigned AMP_W  = 11,
  localparam int unsigned HALF_W = PER_W - 1,
  localparam int unsigned OFS_W  = AMP_W + 1,
  localparam int unsigned CW     = (AMP_W > PER_W) ? AMP_W : PER_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    step,
  input  logic                    park,
  input  logic                    up,
  input  logic [HALF_W-1:0]       half,
  input  logic [AMP_W-1:0]        amp,
  output logic signed [OFS_W-1:0] offset
);
  typedef struct packed {
    logic [AMP_W-1:0]  level;
    logic [HALF_W-1:0] rem;
  } ramp_st_t;

  // One step of level += / -= amp/half, the fraction kept in rem.
  function automatic ramp_st_t next_state(input ramp_st_t cur,
                                          input logic [HALF_W-1:0] h,
                                          input logic [AMP_W-1:0] a,
                                          input logic dir_up);
    logic [CW-1:0] hd, q, r, s, delta;
    ramp_st_t nx;
    hd = (h == '0) ? CW'(1) : CW'(h);
    q  = CW'(a) / hd;
    r  = CW'(a) % hd;
    s  = CW'(cur.rem) + r;
    if (s >= hd) begin
      s     = s - hd;
      delta = q + CW'(1);
    end else begin
      delta = q;
    end
    nx.rem   = HALF_W'(s);
    nx.level = dir_up ? cur.level + AMP_W'(delta) : cur.level - AMP_W'(delta);
    return nx;
  endfunction

  // Map level in [0, a] onto the centred range [-a, +a].
  function automatic logic signed [OFS_W-1:0] centred(input logic [AMP_W-1:0] lvl,
                                                      input logic [AMP_W-1:0] a);
    logic signed [OFS_W:0] t;
    t = $signed({1'b0, lvl, 1'b0}) - $signed({2'b00, a});
    return $signed(t[OFS_W-1:0]);
  endfunction

  ramp_st_t st_q, st_nx;
  logic signed [OFS_W-1:0] offset_q;

  always_comb st_nx = next_state(st_q, half, amp, up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= '0;
      offset_q <= '0;
    end else if (!enable || park) begin
      st_q     <= '0;
      offset_q <= '0;
    end else if (step) begin
      st_q     <= st_nx;
      offset_q <= centred(st_nx.level, amp);
    end
  end

  assign offset = offset_q;
endmodule

// File: rtl/tri_spread_ctl.sv
module tri_spread_ctl
  import tri_spread_pkg::*;
#(
  parameter  int unsigned PER_W  = DEF_PER_W,
  parameter  int unsigned AMP_W  = DEF_AMP_W,
  parameter  int unsigned MOD_W  = DEF_MOD_W,
  localparam int unsigned HALF_W = PER_W - 1,
  localparam int unsigned OFS_W  = AMP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    ss_en_n,
  input  logic [PER_W-1:0]        cfg_period,
  input  logic [AMP_W-1:0]        cfg_amp,
  input  logic [MOD_W-1:0]        cfg_mod,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    dir_up_o,
  output logic                    period_start_o,
  output logic [MOD_W-1:0]        mod_o
);
  logic              enable;
  logic [HALF_W-1:0] cfg_half, act_half, eff_half;
  logic [AMP_W-1:0]  act_amp, eff_amp;
  logic              at_bound, start_evt, step_evt, park_evt, go_up;

  assign enable   = !ss_en_n;
  assign cfg_half = cfg_period[PER_W-1:1];
  assign eff_amp  = at_bound ? cfg_amp : act_amp;

  tri_spread_seq #(.PER_W(PER_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (tick),
    .cfg_half  (cfg_half),
    .act_half  (act_half),
    .at_bound  (at_bound),
    .eff_half  (eff_half),
    .start_evt (start_evt),
    .step_evt  (step_evt),
    .park_evt  (park_evt),
    .go_up     (go_up),
    .dir_up    (dir_up_o),
    .strobe    (period_start_o)
  );

  tri_spread_shadow #(.HALF_W(HALF_W), .AMP_W(AMP_W), .MOD_W(MOD_W)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start_evt),
    .half_d (cfg_half),
    .amp_d  (cfg_amp),
    .mod_d  (cfg_mod),
    .half_q (act_half),
    .amp_q  (act_amp),
    .mod_q  (mod_o)
  );

  tri_spread_ramp #(.PER_W(PER_W), .AMP_W(AMP_W)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .step   (step_evt),
    .park   (park_evt),
    .up     (go_up),
    .half   (eff_half),
    .amp    (eff_amp),
    .offset (offset_o)
  );
endmodule

// File: rtl/tri_spread_chk.sv
module tri_spread_chk #(
  parameter int unsigned AMP_W = 11,
  parameter int unsigned MOD_W = 13
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  ss_en_n,
  input logic                  park_evt,
  input logic signed [AMP_W:0] offset_o,
  input logic                  dir_up_o,
  input logic                  period_start_o,
  input logic [MOD_W-1:0]      mod_o
);
  assert_clear_on_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ss_en_n |=> (offset_o == '0) && !dir_up_o && !period_start_o);

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    period_start_o |=> !period_start_o);

  assert_mod_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start_o |-> $stable(mod_o));

  assert_park_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    park_evt |=> (offset_o == '0) && !period_start_o && !dir_up_o);

  assert_first_step_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    period_start_o |-> dir_up_o);

  assert_first_step_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_start_o |-> (offset_o <= 0));

  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ss_en_n) |=> $stable(offset_o) && $stable(dir_up_o) && $stable(mod_o));
endmodule

bind tri_spread_ctl tri_spread_chk #(.AMP_W(AMP_W), .MOD_W(MOD_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick           (tick),
  .ss_en_n        (ss_en_n),
  .park_evt       (park_evt),
  .offset_o       (offset_o),
  .dir_up_o       (dir_up_o),
  .period_start_o (period_start_o),
  .mod_o          (mod_o)
);

// File: tb/tri_spread_ctl_test.sv
`timescale 1ns/1ps
module tri_spread_ctl_test;
  logic               clk = 1'b0;
  logic               rst_n = 1'b1;
  logic               tick = 1'b0;
  logic               ss_en_n = 1'b0;
  logic [10:0]        cfg_period = '0;
  logic [10:0]        cfg_amp = '0;
  logic [12:0]        cfg_mod = '0;
  logic signed [11:0] offset_o;
  logic               dir_up_o, period_start_o;
  logic [12:0]        mod_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  localparam int NV = 7;
  localparam logic [10:0] VP [NV] = '{11'd8, 11'd4, 11'd6, 11'd20, 11'd13, 11'd100, 11'd640};
  localparam logic [10:0] VA [NV] = '{11'd10, 11'd0, 11'd2047, 11'd7, 11'd100, 11'd1, 11'd321};
  localparam logic [12:0] VM [NV] = '{13'd5, 13'd1, 13'd100, 13'd8191, 13'd33, 13'd2, 13'd160};

  always #2 clk = ~clk;

  tri_spread_ctl uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ss_en_n(ss_en_n),
    .cfg_period(cfg_period), .cfg_amp(cfg_amp), .cfg_mod(cfg_mod),
    .offset_o(offset_o), .dir_up_o(dir_up_o),
    .period_start_o(period_start_o), .mod_o(mod_o)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_off(input int k, input int h, input int a);
    if (k <= h) return 2 * ((k * a) / h) - a;
    return a - 2 * (((k - h) * a) / h);
  endfunction

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  // k-th tick of a period with half h, amplitude a, captured modulus m
  task automatic step_chk(input int k, input int h, input int a, input int m);
    int e;
    e = exp_off(k, h, a);
    do_tick();
    chk("R8 offset", offset_o, e);
    chk("R7 direction", dir_up_o, (k <= h) ? 1 : 0);
    chk("R3 period strobe", period_start_o, (k == 1) ? 1 : 0);
    chk("R4 captured modulus", mod_o, m);
    @(negedge clk);
    chk("R9 offset held without tick", offset_o, e);
    chk("R3 strobe one clock", period_start_o, 0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset offset", offset_o, 0);
    chk("R1 reset direction", dir_up_o, 0);
    chk("R1 reset strobe", period_start_o, 0);
    chk("R1 reset modulus", mod_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 offset before first tick", offset_o, 0);
    chk("R1 modulus before first tick", mod_o, 0);

    // table of profiles, back to back (R5 via the odd entry 13)
    for (int i = 0; i < NV; i++) begin
      int h;
      cfg_period = VP[i];
      cfg_amp    = VA[i];
      cfg_mod    = VM[i];
      h = int'(VP[i]) / 2;
      for (int k = 1; k <= 2 * h; k++) step_chk(k, h, int'(VA[i]), int'(VM[i]));
    end

    // R4: change mid-period must wait for the boundary
    cfg_period = 11'd8; cfg_amp = 11'd10; cfg_mod = 13'd5;
    for (int k = 1; k <= 2; k++) step_chk(k, 4, 10, 5);
    cfg_period = 11'd12; cfg_amp = 11'd40; cfg_mod = 13'd77;
    for (int k = 3; k <= 8; k++) step_chk(k, 4, 10, 5);
    step_chk(1, 6, 40, 77);
    step_chk(2, 6, 40, 77);

    // R2: disable in mid-ramp, then restart from a fresh period
    @(negedge clk) ss_en_n = 1'b1;
    @(negedge clk);
    chk("R2 disabled offset", offset_o, 0);
    chk("R2 disabled direction", dir_up_o, 0);
    do_tick();
    chk("R2 tick ignored offset", offset_o, 0);
    chk("R2 tick ignored strobe", period_start_o, 0);
    ss_en_n = 1'b0;
    for (int k = 1; k <= 12; k++) step_chk(k, 6, 40, 77);

    // R6: period below 4 parks the offset at zero
    cfg_period = 11'd3; cfg_amp = 11'd50; cfg_mod = 13'd999;
    do_tick();
    chk("R6 short period offset", offset_o, 0);
    chk("R6 short period strobe", period_start_o, 0);
    chk("R6 short period direction", dir_up_o, 0);
    chk("R6 short period modulus kept", mod_o, 77);
    cfg_period = 11'd0;
    do_tick();
    chk("R6 zero period offset", offset_o, 0);
    chk("R6 zero period modulus kept", mod_o, 77);

    // R5: odd count 9 runs as 8, wraps after 8 ticks
    cfg_period = 11'd9; cfg_amp = 11'd10; cfg_mod = 13'd9;
    for (int k = 1; k <= 8; k++) step_chk(k, 4, 10, 9);
    step_chk(1, 4, 10, 9);
    chk("R5 odd period restarts at tick 9", offset_o, -6);

    summary();
  end
endmodule